// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block turns one high-level flash operation into the chain of 16-bit bus write cycles that a parallel NOR memory expects. The operations it knows are: return to read mode, full reset, identifier entry, single-word program, block erase, whole-chip erase and buffered program. Each one is taken from a single-cycle request port while the block is idle. The block then drives a request/acknowledge write port toward a memory bus master. The addresses on that port are halfword addresses.

Most commands open with a two-cycle unlock preamble. Erases repeat that preamble after the erase setup cycle. A buffered program frames its data words between a load command plus word count at the front and a confirm command at the back. The data words come in through a valid/ready stream while the sequence runs. A one-cycle done pulse follows the final write cycle. After that pulse, a separate status unit polls the memory for the end of the embedded operation. A request the block cannot carry out raises a one-cycle error pulse and issues no bus cycles.

Top module: `nor_cmd_seq`

## Requirements
- R1: Every operation except return-to-read (code 0) begins with data 0xAA at address 0x555, followed by data 0x55 at address 0x2AA.
- R2: Code 0 issues a single cycle, 0xF0 at address 0. Code 1 (reset) issues the unlock pair and then 0xF0 at address 0.
- R3: Code 2 (identifier entry) issues the unlock pair and then 0x90 at 0x555. The sequence is then complete.
- R4: Code 3 (program word) issues the unlock pair, then 0xA0 at 0x555, then the request data at the request address.
- R5: Code 4 (block erase) issues the unlock pair, then 0x80 at 0x555, then the unlock pair again, then 0x30 at the request address.
- R6: Code 5 (chip erase) issues the same first five cycles as block erase. Its sixth cycle is 0x10 at 0x555.
- R7: Code 6 (buffered program) with count N issues the following cycles in order: the unlock pair; 0x25 at the start address A; N-1 at A; stream words k=0..N-1 at A+k; then 0x29 at A+N-1.
- R8: A request with code 7 is rejected. A buffered program with count 0 or count above 32 is also rejected. A rejection produces a one-cycle err pulse, issues no bus cycles and gives no done pulse.
- R9: bus_req stays high with bus_addr and bus_data unchanged until bus_ack is seen. Each cycle with both bus_req and bus_ack high transfers exactly one write.
- R10: done pulses for one cycle, in the cycle after the final transfer. op_ready is high in that cycle, and a request presented then is accepted.
- R11: wd_ready is high only in a cycle where a stream word is transferred on the bus. Exactly N words are consumed per buffered program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request strobe |
| op_code | input | 3 | Operation code (0..6, 7 reserved) |
| op_addr | input | AW | Target, block or start halfword address |
| op_data | input | 16 | Word for single-word program |
| op_count | input | 6 | Word count for buffered program |
| op_ready | output | 1 | Idle; a request is accepted this cycle |
| wd_valid | input | 1 | Stream word available |
| wd_data | input | 16 | Stream word |
| wd_ready | output | 1 | Stream word consumed this cycle |
| bus_req | output | 1 | Write cycle request to bus master |
| bus_addr | output | AW | Halfword address of write cycle |
| bus_data | output | 16 | Data of write cycle |
| bus_ack | input | 1 | Bus master accepts the write cycle |
| done | output | 1 | Final cycle of the sequence issued |
| err | output | 1 | Request rejected |

## Verification
Two things can land in the same cycle: the done pulse of one sequence and the acceptance of the next request. The bench provokes this by waiting for done and presenting a second operation in that exact cycle. It then judges that op_ready is high alongside done, and that the second operation's cycles follow the first's on the bus with nothing lost or repeated. Variable acknowledge stalls are also applied. These show that a held request is never duplicated and that stream words advance only on a transfer.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int AW   = 24,
  parameter int MAXW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [AW-1:0] op_addr,
  input  logic [15:0]   op_data,
  input  logic [5:0]    op_count,
  output logic          op_ready,
  input  logic          wd_valid,
  input  logic [15:0]   wd_data,
  output logic          wd_ready,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_data,
  input  logic          bus_ack,
  output logic          done,
  output logic          err
);
  localparam logic [2:0] C_RDM = 3'd0, C_RST = 3'd1, C_ID = 3'd2, C_PGM = 3'd3,
                         C_BER = 3'd4, C_CER = 3'd5, C_BUF = 3'd6;
  localparam logic [AW-1:0] A_U1 = AW'(12'h555);
  localparam logic [AW-1:0] A_U2 = AW'(12'h2AA);

  logic          busy;
  logic [2:0]    op_q;
  logic [2:0]    step;
  logic [AW-1:0] addr_q;
  logic [15:0]   data_q;
  logic [5:0]    cnt_q;
  logic [5:0]    widx;
  logic          last, stream, xfer, bad;

  assign op_ready = !busy;
  assign bad      = (op_code == 3'd7) ||
                    (op_code == C_BUF && (op_count == 6'd0 || 32'(op_count) > MAXW));
  assign bus_req  = busy && (!stream || wd_valid);
  assign xfer     = bus_req && bus_ack;
  assign wd_ready = xfer && stream;

  always_comb begin
    bus_addr = '0;
    bus_data = 16'h0000;
    last     = 1'b0;
    stream   = 1'b0;
    if (op_q == C_RDM) begin
      bus_data = 16'h00F0;
      last     = 1'b1;
    end else if (step == 3'd0 || ((op_q == C_BER || op_q == C_CER) && step == 3'd3)) begin
      bus_addr = A_U1;
      bus_data = 16'h00AA;
    end else if (step == 3'd1 || ((op_q == C_BER || op_q == C_CER) && step == 3'd4)) begin
      bus_addr = A_U2;
      bus_data = 16'h0055;
    end else begin
      case (op_q)
        C_RST: begin bus_data = 16'h00F0; last = 1'b1; end
        C_ID:  begin bus_addr = A_U1; bus_data = 16'h0090; last = 1'b1; end
        C_PGM:
          if (step == 3'd2) begin bus_addr = A_U1; bus_data = 16'h00A0; end
          else begin bus_addr = addr_q; bus_data = data_q; last = 1'b1; end
        C_BER, C_CER:
          if (step == 3'd2) begin bus_addr = A_U1; bus_data = 16'h0080; end
          else if (op_q == C_BER) begin bus_addr = addr_q; bus_data = 16'h0030; last = 1'b1; end
          else begin bus_addr = A_U1; bus_data = 16'h0010; last = 1'b1; end
        default:
          case (step)
            3'd2: begin bus_addr = addr_q; bus_data = 16'h0025; end
            3'd3: begin bus_addr = addr_q; bus_data = 16'(cnt_q - 6'd1); end
            3'd4: begin bus_addr = addr_q + AW'(widx); bus_data = wd_data; stream = 1'b1; end
            default: begin
              bus_addr = addr_q + AW'(cnt_q - 6'd1);
              bus_data = 16'h0029;
              last     = 1'b1;
            end
          endcase
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; op_q <= C_RDM; step <= '0; addr_q <= '0; data_q <= '0;
      cnt_q <= '0; widx <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        if (op_valid) begin
          if (bad) err <= 1'b1;
          else begin
            busy   <= 1'b1;
            op_q   <= op_code;
            addr_q <= op_addr;
            data_q <= op_data;
            cnt_q  <= op_count;
            step   <= '0;
            widx   <= '0;
          end
        end
      end else if (xfer) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (stream) begin
          widx <= widx + 6'd1;
          if (widx == cnt_q - 6'd1) step <= step + 3'd1;
        end else begin
          step <= step + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_ready,
  input logic          wd_ready,
  input logic          bus_req,
  input logic [AW-1:0] bus_addr,
  input logic [15:0]   bus_data,
  input logic          bus_ack,
  input logic          done,
  input logic          err
);
  assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> !bus_req);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> op_ready);
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  assert_err_no_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> op_ready && !done);
  assert_stream_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> bus_req && bus_ack);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_ready(op_ready), .wd_ready(wd_ready),
  .bus_req(bus_req), .bus_addr(bus_addr), .bus_data(bus_data),
  .bus_ack(bus_ack), .done(done), .err(err)
);

// File: tb/sim_nor_cmd_seq.sv
`timescale 1ns/1ps
module sim_nor_cmd_seq;
  localparam int AW = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [AW-1:0] op_addr = '0;
  logic [15:0] op_data = '0;
  logic [5:0] op_count = '0;
  logic op_ready, wd_valid, wd_ready, bus_req, bus_ack = 1'b0, done, err;
  logic [15:0] wd_data, bus_data;
  logic [AW-1:0] bus_addr;

  always #2.5 clk = ~clk;

  nor_cmd_seq #(.AW(AW), .MAXW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_data(op_data), .op_count(op_count), .op_ready(op_ready),
    .wd_valid(wd_valid), .wd_data(wd_data), .wd_ready(wd_ready),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_data(bus_data), .bus_ack(bus_ack),
    .done(done), .err(err));

  int checks = 0, errors = 0;
  logic [AW-1:0] lg_a [0:63];
  logic [15:0]   lg_d [0:63];
  logic [AW-1:0] ex_a [0:63];
  logic [15:0]   ex_d [0:63];
  logic [15:0]   wbuf [0:63];
  int lg_n = 0, ex_n = 0, done_n = 0, err_n = 0, ready_miss = 0;
  int stall = 0, stall_cnt = 0, widx_tb = 0, strm_n = 0;
  logic adv_pend = 1'b0;

  assign wd_valid = widx_tb < strm_n;
  assign wd_data  = wbuf[widx_tb[5:0]];

  always @(negedge clk) begin
    if (done) begin done_n++; if (!op_ready) ready_miss++; end
    if (err) err_n++;
    if (bus_req && stall_cnt >= stall) begin
      bus_ack = 1'b1;
      if (lg_n < 64) begin lg_a[lg_n] = bus_addr; lg_d[lg_n] = bus_data; end
      lg_n++;
      stall_cnt = 0;
    end else begin
      bus_ack = 1'b0;
      if (bus_req) stall_cnt++;
    end
    #1 if (wd_ready) adv_pend = 1'b1;
  end

  always @(posedge clk) begin
    #1 if (adv_pend) begin widx_tb++; adv_pend = 1'b0; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_cyc(input logic [AW-1:0] a, input logic [15:0] d);
    ex_a[ex_n] = a; ex_d[ex_n] = d; ex_n++;
  endtask

  task automatic unlock();
    expect_cyc(24'h555, 16'h00AA);
    expect_cyc(24'h2AA, 16'h0055);
  endtask

  task automatic clear();
    lg_n = 0; ex_n = 0; done_n = 0; err_n = 0; ready_miss = 0;
    widx_tb = 0; strm_n = 0; stall_cnt = 0;
  endtask

  task automatic issue(input logic [2:0] c, input logic [AW-1:0] a,
                       input logic [15:0] d, input logic [5:0] n);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_addr = a; op_data = d; op_count = n;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 3000 && done_n == 0 && err_n == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string req);
    check(lg_n == ex_n, req, "cycle count", lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      check(lg_a[i] == ex_a[i], req, $sformatf("addr of cycle %0d", i), lg_a[i], ex_a[i]);
      check(lg_d[i] == ex_d[i], req, $sformatf("data of cycle %0d", i), lg_d[i], ex_d[i]);
    end
    check(done_n == 1, "R10", "done pulses", done_n, 1);
    check(ready_miss == 0, "R10", "op_ready during done", ready_miss, 0);
  endtask

  task automatic t_reset();
    check(op_ready == 1'b1, "R10", "op_ready after reset", op_ready, 1);
    check(bus_req == 1'b0, "R9", "bus_req after reset", bus_req, 0);
    check(done == 1'b0 && err == 1'b0, "R8", "done/err after reset", {done, err}, 0);
  endtask

  task automatic t_readmode();
    clear(); stall = 0;
    expect_cyc(24'h0, 16'h00F0);
    issue(3'd0, 24'h1234, 16'h0, 6'd0); settle(); compare("R2");
  endtask

  task automatic t_rst();
    clear(); stall = 1;
    unlock(); expect_cyc(24'h0, 16'h00F0);
    issue(3'd1, 24'h00ABCD, 16'h0, 6'd0); settle(); compare("R2");
  endtask

  task automatic t_id();
    clear(); stall = 0;
    unlock(); expect_cyc(24'h555, 16'h0090);
    issue(3'd2, 24'h0, 16'h0, 6'd0); settle(); compare("R3");
  endtask

  task automatic t_pgm();
    clear(); stall = 2;
    unlock(); expect_cyc(24'h555, 16'h00A0); expect_cyc(24'h03_4567, 16'hBEEF);
    issue(3'd3, 24'h03_4567, 16'hBEEF, 6'd0); settle(); compare("R4");
  endtask

  task automatic t_erase(input bit chip);
    clear(); stall = chip ? 0 : 3;
    unlock(); expect_cyc(24'h555, 16'h0080); unlock();
    if (chip) expect_cyc(24'h555, 16'h0010);
    else expect_cyc(24'h02_0000, 16'h0030);
    issue(chip ? 3'd5 : 3'd4, 24'h02_0000, 16'h0, 6'd0); settle();
    compare(chip ? "R6" : "R5");
  endtask

  task automatic t_buf(input int n, input int st, input logic [AW-1:0] a);
    clear(); stall = st;
    for (int i = 0; i < n; i++) wbuf[i] = 16'h5A00 + 16'(i * 7);
    unlock(); expect_cyc(a, 16'h0025); expect_cyc(a, 16'(n - 1));
    for (int i = 0; i < n; i++) expect_cyc(a + AW'(i), wbuf[i]);
    expect_cyc(a + AW'(n - 1), 16'h0029);
    strm_n = n;
    issue(3'd6, a, 16'h0, 6'(n)); settle(); compare("R7");
    check(widx_tb == n, "R11", "stream words consumed", widx_tb, n);
  endtask

  task automatic t_reject(input logic [2:0] c, input logic [5:0] n);
    clear(); stall = 0; strm_n = 4;
    issue(c, 24'h100, 16'h0, n); settle();
    check(err_n == 1, "R8", "err pulses", err_n, 1);
    check(lg_n == 0, "R8", "bus cycles on reject", lg_n, 0);
    check(done_n == 0, "R8", "done on reject", done_n, 0);
    check(widx_tb == 0, "R11", "stream words on reject", widx_tb, 0);
  endtask

  task automatic t_b2b();
    clear(); stall = 1;
    expect_cyc(24'h0, 16'h00F0); unlock(); expect_cyc(24'h555, 16'h0090);
    issue(3'd0, 24'h0, 16'h0, 6'd0);
    for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    check(done && op_ready, "R10", "done with op_ready", {done, op_ready}, 3);
    op_valid = 1'b1; op_code = 3'd2; op_addr = '0;
    @(negedge clk); op_valid = 1'b0;
    check(!op_ready, "R10", "second op taken in done cycle", op_ready, 0);
    for (int i = 0; i < 100 && done_n < 2; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(done_n == 2, "R10", "done pulses back to back", done_n, 2);
    check(lg_n == ex_n, "R1", "cycles back to back", lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++)
      check(lg_a[i] == ex_a[i] && lg_d[i] == ex_d[i], "R1",
            $sformatf("cycle %0d back to back", i), {lg_a[i], lg_d[i]}, {ex_a[i], ex_d[i]});
  endtask

  bit finished = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readmode();
    t_rst();
    t_id();
    t_pgm();
    t_erase(1'b0);
    t_erase(1'b1);
    t_buf(3, 1, 24'h00_4000);
    t_buf(1, 0, 24'h00_8010);
    t_buf(32, 2, 24'h01_0000);
    t_reject(3'd6, 6'd0);
    t_reject(3'd6, 6'd33);
    t_reject(3'd7, 6'd1);
    t_b2b();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule